// File: doc/BRIEF.md
# USB Device Interrupt Collector

This block gathers event requests from a USB device's serial interface engine into two groups and folds them into a single active-low interrupt line for a microcontroller. The first group holds four bus-level sources: bus reset, suspend, resume and start-of-frame. The second group holds one request for each of four endpoints. The engine reports each event as a one-cycle strobe, and the strobe latches a pending bit.

Firmware sees the pending bits, the enable bits and a per-group summary through a small register port with a combinational read. It clears a pending bit by writing 1 to it. The enable bits mask only the interrupt line; pending bits latch whether or not they are enabled. The line is registered, so it changes only at a clock edge. It stays low until no pending bit in either group is also enabled.

Top module: `usb_irq_collector`

## Requirements
- R1: A synchronous reset clears every pending bit and every enable bit and drives `irq_n` high.
- R2: A strobe on `bus_evt[i]` sets bit i of the bus pending register at address 0 at the next clock edge. The bit positions are 0 bus reset, 1 suspend, 2 resume and 3 start-of-frame.
- R3: A strobe on `ep_evt[n]` sets bit n of the endpoint pending register at address 2 at the next clock edge.
- R4: A write to address 0 or 2 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged. With no such write, a pending bit never drops.
- R5: When a strobe and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: The bus enable register at address 1 and the endpoint enable register at address 3 can be written and read back. A pending bit latches even when its enable is 0.
- R7: When an enabled bit becomes pending, `irq_n` goes low at the same clock edge that sets the bit.
- R8: `irq_n` stays low while at least one pending bit in either group is enabled. It returns high at the edge where the last such bit is cleared or masked.
- R9: Writing an enable bit to 1 while its pending bit is already set drives `irq_n` low at that write's clock edge.
- R10: The read-only summary at address 4 has bit 0 set when any bus pending bit is set and bit 1 set when any endpoint pending bit is set. Writes to address 4 have no effect, and addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_evt | input | 4 | One-cycle bus event strobes (reset, suspend, resume, start-of-frame) |
| ep_evt | input | 4 | One-cycle endpoint event strobes, one per endpoint |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Combinational read data for `reg_addr` |
| irq_n | output | 1 | Interrupt line to the microcontroller, active low |

## Verification
Every register result, and `irq_n`, is due one clock edge after the strobe or write that causes it. The line is registered from the next-state values, so it moves at the same edge as the pending and enable bits. The read data is combinational on the current address and already reflects that edge. The bench drives each input set at a falling edge and lets one rising edge pass. At the next falling edge it updates its own model and compares both `irq_n` and the read data for the address it drove. This includes cycles where a strobe and a clear, or a clear and an enable write, meet.

// File: rtl/usb_irq_collector.sv
module usb_irq_collector #(
  parameter int NUM_BUS = 4,
  parameter int NUM_EP  = 4,
  parameter int AW      = 3,
  parameter int DW      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_BUS-1:0] bus_evt,
  input  logic [NUM_EP-1:0]  ep_evt,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_n
);

  localparam logic [AW-1:0] A_BUS_PEND = AW'(0);
  localparam logic [AW-1:0] A_BUS_EN   = AW'(1);
  localparam logic [AW-1:0] A_EP_PEND  = AW'(2);
  localparam logic [AW-1:0] A_EP_EN    = AW'(3);
  localparam logic [AW-1:0] A_SUMMARY  = AW'(4);

  logic [NUM_BUS-1:0] bus_pend, bus_en, bus_pend_nx, bus_en_nx;
  logic [NUM_EP-1:0]  ep_pend, ep_en, ep_pend_nx, ep_en_nx;

  wire wr_bus_pend = reg_wr && (reg_addr == A_BUS_PEND);
  wire wr_bus_en   = reg_wr && (reg_addr == A_BUS_EN);
  wire wr_ep_pend  = reg_wr && (reg_addr == A_EP_PEND);
  wire wr_ep_en    = reg_wr && (reg_addr == A_EP_EN);

  assign bus_pend_nx = (bus_pend & ~(wr_bus_pend ? reg_wdata[NUM_BUS-1:0] : '0)) | bus_evt;
  assign ep_pend_nx  = (ep_pend  & ~(wr_ep_pend  ? reg_wdata[NUM_EP-1:0]  : '0)) | ep_evt;
  assign bus_en_nx   = wr_bus_en ? reg_wdata[NUM_BUS-1:0] : bus_en;
  assign ep_en_nx    = wr_ep_en  ? reg_wdata[NUM_EP-1:0]  : ep_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_pend <= '0;
      bus_en   <= '0;
      ep_pend  <= '0;
      ep_en    <= '0;
      irq_n    <= 1'b1;
    end else begin
      bus_pend <= bus_pend_nx;
      bus_en   <= bus_en_nx;
      ep_pend  <= ep_pend_nx;
      ep_en    <= ep_en_nx;
      irq_n    <= ~(|(bus_pend_nx & bus_en_nx) | |(ep_pend_nx & ep_en_nx));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_BUS_PEND: reg_rdata[NUM_BUS-1:0] = bus_pend;
      A_BUS_EN:   reg_rdata[NUM_BUS-1:0] = bus_en;
      A_EP_PEND:  reg_rdata[NUM_EP-1:0]  = ep_pend;
      A_EP_EN:    reg_rdata[NUM_EP-1:0]  = ep_en;
      A_SUMMARY:  reg_rdata[1:0]         = {|ep_pend, |bus_pend};
      default:    reg_rdata = '0;
    endcase
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (irq_n && bus_pend == '0 && ep_pend == '0 && bus_en == '0 && ep_en == '0)); // R1

  AST_BUS_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|bus_evt) |=> ((bus_pend & $past(bus_evt)) == $past(bus_evt))); // R5

  AST_EP_SET: assert property (@(posedge clk) disable iff (rst)
    (|ep_evt) |=> ((ep_pend & $past(ep_evt)) == $past(ep_evt))); // R3

  AST_BUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_bus_pend |=> ((bus_pend & $past(bus_pend)) == $past(bus_pend))); // R4

  AST_EP_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_ep_pend |=> ((ep_pend & $past(ep_pend)) == $past(ep_pend))); // R4

  AST_FALL_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    ((|(bus_evt & bus_en) && !wr_bus_en) || (|(ep_evt & ep_en) && !wr_ep_en)) |=> !irq_n); // R7

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (|(bus_pend & bus_en) || |(ep_pend & ep_en)) |-> !irq_n); // R8

  AST_LATE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_bus_en && |(reg_wdata[NUM_BUS-1:0] & bus_pend)) |=> !irq_n); // R9

endmodule

// File: tb/usb_irq_collector_bench.sv
`timescale 1ns/1ps
module usb_irq_collector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_evt = '0, ep_evt = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [3:0] reg_rdata;
  logic       irq_n;

  int checks = 0, errors = 0;
  logic [3:0] m_bp = '0, m_be = '0, m_ep = '0, m_ee = '0;

  always #2 clk = ~clk;

  usb_irq_collector u_usb_irq_collector (
    .clk(clk), .rst(rst), .bus_evt(bus_evt), .ep_evt(ep_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n));

  function automatic logic [3:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_bp;
      3'd1: return m_be;
      3'd2: return m_ep;
      3'd3: return m_ee;
      3'd4: return {2'b00, |m_ep, |m_bp};
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return ~(|(m_bp & m_be) | |(m_ep & m_ee));
  endfunction

  task automatic check(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] be, input logic [3:0] ee, input logic wr,
                      input logic [2:0] a, input logic [3:0] d, input string tag);
    bus_evt = be; ep_evt = ee; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      m_bp = '0; m_be = '0; m_ep = '0; m_ee = '0;
    end else begin
      m_bp = (m_bp & ~((wr && a == 3'd0) ? d : 4'h0)) | be;
      m_ep = (m_ep & ~((wr && a == 3'd2) ? d : 4'h0)) | ee;
      if (wr && a == 3'd1) m_be = d;
      if (wr && a == 3'd3) m_ee = d;
    end
    check(tag, "irq_n", {3'b000, irq_n}, {3'b000, exp_irq()});
    check(tag, "rdata", reg_rdata, exp_read(a));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2085));
    @(negedge clk);
    step('0, '0, 1'b0, 3'd0, '0, "R1");
    rst = 1'b0;
    for (int a = 0; a < 5; a++) step('0, '0, 1'b0, 3'(a), '0, "R1");

    step(4'b0001, '0, 1'b0, 3'd0, '0, "R2");        // bus reset latches while masked
    step('0, '0, 1'b0, 3'd0, '0, "R6");
    step('0, '0, 1'b1, 3'd1, 4'b0001, "R9");        // late enable asserts irq
    step(4'b1000, '0, 1'b1, 3'd1, 4'b1111, "R6");
    step('0, '0, 1'b1, 3'd0, 4'b0001, "R8");        // bit 3 still pending
    step('0, '0, 1'b1, 3'd0, 4'b0000, "R4");        // zero bits ignored
    step('0, '0, 1'b1, 3'd0, 4'b1000, "R8");        // last one cleared
    step('0, 4'b0100, 1'b0, 3'd2, '0, "R3");
    step('0, 4'b0100, 1'b1, 3'd2, 4'b0100, "R5");   // set beats clear
    step('0, '0, 1'b1, 3'd3, 4'b0100, "R9");
    step('0, 4'b0010, 1'b0, 3'd4, '0, "R10");
    step('0, '0, 1'b1, 3'd4, 4'hF, "R10");          // summary ignores writes
    step('0, '0, 1'b0, 3'd5, '0, "R10");
    step('0, '0, 1'b1, 3'd3, 4'b0000, "R8");        // masking releases line
    step('0, '0, 1'b1, 3'd2, 4'b1111, "R4");
    step(4'b0010, '0, 1'b0, 3'd0, '0, "R7");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] be, ee, d;
      logic wr;
      logic [2:0] a;
      string tag;
      be = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
      ee = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
      wr = ($urandom % 2 == 0);
      a  = 3'($urandom);
      d  = 4'($urandom);
      case (a)
        3'd0: tag = "R2";
        3'd2: tag = "R3";
        3'd1, 3'd3: tag = "R6";
        default: tag = "R10";
      endcase
      if (wr && (a == 3'd0 || a == 3'd2)) tag = "R4";
      if (wr && ((a == 3'd0 && |(be & d)) || (a == 3'd2 && |(ee & d)))) tag = "R5";
      if (!wr && (|be || |ee)) tag = "R7";
      step(be, ee, wr, a, d, tag);
    end

    rst = 1'b1;
    step(4'hF, 4'hF, 1'b0, 3'd0, '0, "R1");
    rst = 1'b0;
    step('0, '0, 1'b0, 3'd4, '0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule